// File: doc/BRIEF.md
# Destination Address Cache with Idle Aging

This block is a small, fully associative cache of destination station addresses for a Layer 2 switch. Every entry keeps a 48-bit address, the egress port it maps to, and some bookkeeping: an occupied flag, a pinned flag and a keep-preferred flag set by management, a reuse flag, an idle counter and a recency rank. The forwarding path presents an address on the lookup port. One cycle later it gets hit or miss and the stored port. A hit also makes that entry the most recent one. The reuse flag records that an entry was touched again after it was inserted.

The learn port inserts new addresses or refreshes known ones. When no slot is free, a victim is chosen on the spot from the entries that are not pinned. A free slot is used first. After that come unpinned, non-preferred entries used only once, then unpinned, non-preferred entries that have been reused, and last the preferred entries. Within each group the least recently used entry goes first. If every entry is pinned, the learn is refused and flagged.

A management port pins or unpins an entry and sets or clears its preference. A periodic tick ages every unpinned entry in parallel and drops the entries that have stayed idle up to a programmable limit. If a learn and a lookup arrive in the same cycle, the learn owns the recency and idle update. The lookup is still answered from the contents held before that edge.

Top module: `mac_age_cache`

## Requirements
- R1: After reset every entry is empty, so every lookup misses, and lookup_rsp_valid, learn_ack and learn_full are low until a request arrives.
- R2: A lookup request in cycle t gives lookup_rsp_valid high in cycle t+1. In that cycle lookup_hit is 1 and lookup_port is the stored port when a valid entry holds the address; otherwise lookup_hit is 0 and lookup_port is 0.
- R3: A learn of an absent address that finds a free or replaceable entry gives learn_ack high and learn_full low one cycle later. From then on, lookups of that address hit with the learned port. A free entry is always taken before any occupied entry is evicted.
- R4: A learn of an address that is already present overwrites its port and refreshes it. No second copy is created, so all other cached addresses still hit afterwards.
- R5: On each cycle with age_tick high, every valid, unpinned entry that is not touched in that cycle increments its idle counter, which saturates at 15. An entry whose incremented count reaches or passes age_limit becomes invalid. A hit or a learn clears the counter. age_limit = 0 turns off aging.
- R6: A pinned entry is never aged out and never chosen as a victim.
- R7: Victim groups are tried in this order: free entries (lowest index first), unpinned non-preferred single-use entries, unpinned non-preferred reused entries, unpinned preferred entries. A lookup hit or a learn refresh marks an entry reused; an insertion clears the mark.
- R8: Within a victim group the least recently used entry is evicted. A lookup hit or a learn makes an entry the most recent at the same clock edge that registers the response.
- R9: When every entry is valid and pinned, a learn of an absent address is refused. learn_ack and learn_full are both high one cycle later, and the cache contents do not change.
- R10: A management write sets the pinned flag to mgmt_lock and the preferred flag to mgmt_prio on the entry that holds mgmt_mac. It has no effect when no entry holds that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_valid | input | 1 | Lookup request |
| lookup_mac | input | 48 | Address to look up |
| lookup_rsp_valid | output | 1 | Lookup result valid (one cycle after request) |
| lookup_hit | output | 1 | Address found |
| lookup_port | output | 4 | Port of the hit entry, 0 on miss |
| learn_valid | input | 1 | Learn request |
| learn_mac | input | 48 | Address to insert or refresh |
| learn_port | input | 4 | Port to store |
| learn_ack | output | 1 | Learn completed (one cycle after request) |
| learn_full | output | 1 | Learn refused because all entries are pinned |
| mgmt_valid | input | 1 | Management write |
| mgmt_mac | input | 48 | Address whose flags are written |
| mgmt_lock | input | 1 | New pinned flag |
| mgmt_prio | input | 1 | New preferred flag |
| age_tick | input | 1 | Aging scan strobe |
| age_limit | input | 4 | Idle limit in ticks, 0 disables aging |

## Verification
Wrong recency ranks, reuse flags or group order do not show up when they are written. They appear at the first learn that has to evict: the wrong address disappears, and the next lookup of the evicted or surviving address misses or hits the wrong way. An idle counter that is cleared or advanced wrongly shows up as a hit or miss some ticks later, when the limit is reached. Because of this, the bench keeps a full reference model of the entries and compares every lookup and learn response against it, so that a divergence is caught at the first response it can affect.

// File: rtl/mac_cache_pkg.sv
package mac_cache_pkg;
    parameter int ENTRIES = 16;
    parameter int MAC_W   = 48;
    parameter int PORT_W  = 4;
    parameter int AGE_W   = 4;
    localparam int IDX_W  = $clog2(ENTRIES);

    typedef struct packed {
        logic              valid;
        logic              lock;
        logic              prio;
        logic              reuse;
        logic [AGE_W-1:0]  age;
        logic [IDX_W-1:0]  rank;   // 0 = most recent
        logic [PORT_W-1:0] port;
        logic [MAC_W-1:0]  mac;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic                 lk_vld;
        logic                 lk_hit;
        logic [PORT_W-1:0]    lk_port;
        logic                 ln_ack;
        logic                 ln_full;
    } state_t;
endpackage

// File: rtl/mac_cache_match.sv
module mac_cache_match #(
    parameter int N  = 16,
    parameter int W  = 48,
    parameter int IW = 4
) (
    input  logic [N-1:0]        valid,
    input  logic [N-1:0][W-1:0] tags,
    input  logic [W-1:0]        key,
    output logic [N-1:0]        vec,
    output logic                hit,
    output logic [IW-1:0]       idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign vec[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        hit = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/mac_cache_victim.sv
module mac_cache_victim #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]         valid,
    input  logic [N-1:0]         lock,
    input  logic [N-1:0]         prio,
    input  logic [N-1:0]         reuse,
    input  logic [N-1:0][IW-1:0] rank,
    output logic                 ok,
    output logic [IW-1:0]        idx
);
    localparam int SW = IW + 2;

    logic [N-1:0]         elig;
    logic [N-1:0][SW-1:0] score;

    // Score = {group, order}; the highest eligible score is the victim.
    for (genvar g = 0; g < N; g++) begin : g_score
        assign elig[g]  = !valid[g] || !lock[g];
        assign score[g] = !valid[g] ? {2'd3, IW'(N - 1 - g)} :
                          prio[g]   ? {2'd0, rank[g]} :
                          reuse[g]  ? {2'd1, rank[g]} :
                                      {2'd2, rank[g]};
    end

    always_comb begin
        logic [SW-1:0] best;
        ok   = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!ok || score[i] > best)) begin
                ok   = 1'b1;
                best = score[i];
                idx  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mac_cache_ager.sv
module mac_cache_ager #(
    parameter int N  = 16,
    parameter int AW = 4
) (
    input  logic                 tick,
    input  logic [AW-1:0]        limit,
    input  logic [N-1:0]         valid,
    input  logic [N-1:0]         lock,
    input  logic [N-1:0]         touch,
    input  logic [N-1:0][AW-1:0] age,
    output logic [N-1:0][AW-1:0] age_nx,
    output logic [N-1:0]         expire
);
    for (genvar g = 0; g < N; g++) begin : g_age
        logic [AW:0] inc;
        logic        active;
        assign inc       = {1'b0, age[g]} + 1'b1;
        assign active    = tick && valid[g] && !lock[g] && !touch[g];
        assign age_nx[g] = !active ? age[g] : (inc[AW] ? age[g] : inc[AW-1:0]);
        assign expire[g] = active && (limit != '0) && (inc >= {1'b0, limit});
    end
endmodule

// File: rtl/mac_age_cache.sv
module mac_age_cache
    import mac_cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lookup_valid,
    input  logic [MAC_W-1:0]  lookup_mac,
    output logic              lookup_rsp_valid,
    output logic              lookup_hit,
    output logic [PORT_W-1:0] lookup_port,
    input  logic              learn_valid,
    input  logic [MAC_W-1:0]  learn_mac,
    input  logic [PORT_W-1:0] learn_port,
    output logic              learn_ack,
    output logic              learn_full,
    input  logic              mgmt_valid,
    input  logic [MAC_W-1:0]  mgmt_mac,
    input  logic              mgmt_lock,
    input  logic              mgmt_prio,
    input  logic              age_tick,
    input  logic [AGE_W-1:0]  age_limit
);
    state_t q, d;

    logic [ENTRIES-1:0]             v_vec, l_vec, p_vec, r_vec;
    logic [ENTRIES-1:0][MAC_W-1:0]  mac_arr;
    logic [ENTRIES-1:0][IDX_W-1:0]  rank_arr;
    logic [ENTRIES-1:0][AGE_W-1:0]  age_arr, age_nx;
    logic [ENTRIES-1:0]             expire, touch_vec;
    logic [ENTRIES-1:0]             lk_vec, ln_vec, mg_vec;
    logic                           lk_hit, ln_hit, mg_hit, vic_ok;
    logic [IDX_W-1:0]               lk_idx, ln_idx, mg_idx, vic_idx;
    logic                           touch_en, insert;
    logic [IDX_W-1:0]               touch_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_unpack
        assign v_vec[g]     = q.ent[g].valid;
        assign l_vec[g]     = q.ent[g].lock;
        assign p_vec[g]     = q.ent[g].prio;
        assign r_vec[g]     = q.ent[g].reuse;
        assign mac_arr[g]   = q.ent[g].mac;
        assign rank_arr[g]  = q.ent[g].rank;
        assign age_arr[g]   = q.ent[g].age;
        assign touch_vec[g] = touch_en && (touch_idx == IDX_W'(g));
    end

    mac_cache_match #(.N(ENTRIES), .W(MAC_W), .IW(IDX_W)) u_lk_match (
        .valid(v_vec), .tags(mac_arr), .key(lookup_mac),
        .vec(lk_vec), .hit(lk_hit), .idx(lk_idx));

    mac_cache_match #(.N(ENTRIES), .W(MAC_W), .IW(IDX_W)) u_ln_match (
        .valid(v_vec), .tags(mac_arr), .key(learn_mac),
        .vec(ln_vec), .hit(ln_hit), .idx(ln_idx));

    mac_cache_match #(.N(ENTRIES), .W(MAC_W), .IW(IDX_W)) u_mg_match (
        .valid(v_vec), .tags(mac_arr), .key(mgmt_mac),
        .vec(mg_vec), .hit(mg_hit), .idx(mg_idx));

    mac_cache_victim #(.N(ENTRIES), .IW(IDX_W)) u_victim (
        .valid(v_vec), .lock(l_vec), .prio(p_vec), .reuse(r_vec),
        .rank(rank_arr), .ok(vic_ok), .idx(vic_idx));

    mac_cache_ager #(.N(ENTRIES), .AW(AGE_W)) u_ager (
        .tick(age_tick), .limit(age_limit), .valid(v_vec), .lock(l_vec),
        .touch(touch_vec), .age(age_arr), .age_nx(age_nx), .expire(expire));

    // Which entry becomes most recent this cycle; learn owns the update.
    assign touch_en  = learn_valid ? (ln_hit || vic_ok) : (lookup_valid && lk_hit);
    assign insert    = learn_valid && !ln_hit && vic_ok;
    assign touch_idx = learn_valid ? (ln_hit ? ln_idx : vic_idx) : lk_idx;

    always_comb begin
        d         = q;
        d.lk_vld  = lookup_valid;
        d.lk_hit  = lookup_valid && lk_hit;
        d.lk_port = (lookup_valid && lk_hit) ? q.ent[lk_idx].port : '0;
        d.ln_ack  = learn_valid;
        d.ln_full = learn_valid && !ln_hit && !vic_ok;

        for (int i = 0; i < ENTRIES; i++) begin
            if (mgmt_valid && mg_hit && mg_idx == IDX_W'(i)) begin
                d.ent[i].lock = mgmt_lock;
                d.ent[i].prio = mgmt_prio;
            end
            d.ent[i].age = age_nx[i];
            if (expire[i]) d.ent[i].valid = 1'b0;
            if (touch_en && (q.ent[i].rank < q.ent[touch_idx].rank))
                d.ent[i].rank = q.ent[i].rank + 1'b1;
        end

        if (touch_en) begin
            d.ent[touch_idx].age   = '0;
            d.ent[touch_idx].rank  = '0;
            d.ent[touch_idx].reuse = !insert;
            if (learn_valid) d.ent[touch_idx].port = learn_port;
            if (insert) begin
                d.ent[touch_idx].mac   = learn_mac;
                d.ent[touch_idx].valid = 1'b1;
                d.ent[touch_idx].lock  = 1'b0;
                d.ent[touch_idx].prio  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            for (int i = 0; i < ENTRIES; i++) q.ent[i].rank <= IDX_W'(i);
        end else begin
            q <= d;
        end
    end

    assign lookup_rsp_valid = q.lk_vld;
    assign lookup_hit       = q.lk_hit;
    assign lookup_port      = q.lk_port;
    assign learn_ack        = q.ln_ack;
    assign learn_full       = q.ln_full;

    logic [ENTRIES-1:0] rank_seen;
    always_comb begin
        rank_seen = '0;
        for (int i = 0; i < ENTRIES; i++) rank_seen[q.ent[i].rank] = 1'b1;
    end

    AST_LOOKUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> lookup_rsp_valid); // R2
    AST_LEARN_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        learn_valid |=> learn_ack); // R3
    AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ln_vec) <= 1); // R4
    AST_FULL_ALL_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        learn_full |-> &(v_vec & l_vec)); // R9
    AST_RANK_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        &rank_seen); // R8

    for (genvar g = 0; g < ENTRIES; g++) begin : g_pin_chk
        AST_PINNED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (q.ent[g].valid && q.ent[g].lock) |=> (q.ent[g].valid && $stable(q.ent[g].mac))); // R6
    end
endmodule

// File: tb/mac_age_cache_bench.sv
module mac_age_cache_bench;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lookup_valid = 1'b0;
    logic [47:0] lookup_mac = '0;
    logic        lookup_rsp_valid, lookup_hit;
    logic [3:0]  lookup_port;
    logic        learn_valid = 1'b0;
    logic [47:0] learn_mac = '0;
    logic [3:0]  learn_port = '0;
    logic        learn_ack, learn_full;
    logic        mgmt_valid = 1'b0;
    logic [47:0] mgmt_mac = '0;
    logic        mgmt_lock = 1'b0, mgmt_prio = 1'b0;
    logic        age_tick = 1'b0;
    logic [3:0]  age_limit = '0;

    always #10 clk = ~clk;

    mac_age_cache u_mac_age_cache (.*);

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference model
    logic [47:0] m_mac  [N];
    int          m_port [N];
    bit          m_vld  [N], m_lock [N], m_prio [N], m_reuse [N];
    int          m_age  [N], m_rank [N];

    function automatic logic [47:0] mac_of(input int k);
        return {16'h0A5C, 32'h1357_0000 + 32'(k * 7 + 1)};
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_lock[i] = 0; m_prio[i] = 0; m_reuse[i] = 0;
            m_age[i] = 0; m_rank[i] = i; m_port[i] = 0; m_mac[i] = '0;
        end
    endfunction

    function automatic int m_find(input logic [47:0] a);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_mac[i] == a) return i;
        return -1;
    endfunction

    function automatic void m_touch(input int k);
        for (int i = 0; i < N; i++) if (m_rank[i] < m_rank[k]) m_rank[i]++;
        m_rank[k] = 0;
        m_age[k]  = 0;
    endfunction

    function automatic int m_victim();
        int best;
        for (int i = 0; i < N; i++) if (!m_vld[i]) return i;
        for (int grp = 0; grp < 3; grp++) begin
            best = -1;
            for (int i = 0; i < N; i++) begin
                bit in_grp;
                in_grp = !m_lock[i] &&
                         ((grp == 0) ? (!m_prio[i] && !m_reuse[i]) :
                          (grp == 1) ? (!m_prio[i] && m_reuse[i]) : m_prio[i]);
                if (in_grp && (best < 0 || m_rank[i] > m_rank[best])) best = i;
            end
            if (best >= 0) return best;
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_reset();
    endtask

    task automatic t_lookup(input logic [47:0] a, input string tag);
        int k;
        bit eh;
        int ep;
        k  = m_find(a);
        eh = (k >= 0);
        ep = eh ? m_port[k] : 0;
        if (eh) begin m_touch(k); m_reuse[k] = 1; end
        lookup_valid = 1'b1; lookup_mac = a;
        @(negedge clk);
        lookup_valid = 1'b0;
        chk(lookup_rsp_valid == 1'b1, "R2", "rsp_valid", 64'(lookup_rsp_valid), 1);
        chk(lookup_hit == eh, tag, "hit", 64'(lookup_hit), 64'(eh));
        chk(lookup_port == 4'(ep), tag, "port", 64'(lookup_port), 64'(ep));
    endtask

    task automatic t_learn(input logic [47:0] a, input int p, input string tag);
        int k;
        bit ef;
        ef = 0;
        k  = m_find(a);
        if (k >= 0) begin
            m_port[k] = p; m_reuse[k] = 1; m_touch(k);
        end else begin
            k = m_victim();
            if (k < 0) ef = 1;
            else begin
                m_mac[k] = a; m_port[k] = p; m_vld[k] = 1; m_lock[k] = 0;
                m_prio[k] = 0; m_reuse[k] = 0; m_touch(k);
            end
        end
        learn_valid = 1'b1; learn_mac = a; learn_port = 4'(p);
        @(negedge clk);
        learn_valid = 1'b0;
        chk(learn_ack == 1'b1, "R3", "ack", 64'(learn_ack), 1);
        chk(learn_full == ef, tag, "full", 64'(learn_full), 64'(ef));
    endtask

    task automatic t_mgmt(input logic [47:0] a, input bit lk, input bit pr);
        int k;
        k = m_find(a);
        if (k >= 0) begin m_lock[k] = lk; m_prio[k] = pr; end
        mgmt_valid = 1'b1; mgmt_mac = a; mgmt_lock = lk; mgmt_prio = pr;
        @(negedge clk);
        mgmt_valid = 1'b0;
    endtask

    task automatic t_tick();
        for (int i = 0; i < N; i++) begin
            if (m_vld[i] && !m_lock[i]) begin
                if (age_limit != 0 && m_age[i] + 1 >= int'(age_limit)) m_vld[i] = 0;
                else if (m_age[i] < 15) m_age[i]++;
            end
        end
        age_tick = 1'b1;
        @(negedge clk);
        age_tick = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_reset();
        do_reset();

        // R1: reset state
        chk(lookup_rsp_valid == 0, "R1", "rsp_valid", 64'(lookup_rsp_valid), 0);
        chk(learn_ack == 0, "R1", "ack", 64'(learn_ack), 0);
        chk(learn_full == 0, "R1", "full", 64'(learn_full), 0);
        t_lookup(mac_of(0), "R1");

        // R3 fill, R4 refresh without duplicate
        age_limit = 4'd0;
        for (int k = 0; k < N; k++) t_learn(mac_of(k), k, "R3");
        for (int k = 0; k < N; k++) t_lookup(mac_of(k), "R3");
        t_learn(mac_of(3), 9, "R4");
        for (int k = 0; k < N; k++) t_lookup(mac_of(k), "R4");

        // R8: LRU among single-use entries, hit refreshes recency
        do_reset();
        for (int k = 0; k < N; k++) t_learn(mac_of(k), k, "R8");
        t_lookup(mac_of(0), "R8");
        t_learn(mac_of(16), 1, "R8");
        t_lookup(mac_of(1), "R8");
        t_lookup(mac_of(2), "R8");
        t_learn(mac_of(17), 2, "R8");
        t_lookup(mac_of(3), "R8");
        t_lookup(mac_of(0), "R8");

        // R7 group order, R6 pinning, R9 refusal, R10 management
        do_reset();
        for (int k = 0; k < N; k++) t_learn(mac_of(k), k, "R7");
        t_mgmt(mac_of(0), 0, 1);
        t_mgmt(mac_of(1), 0, 1);
        t_lookup(mac_of(2), "R7");
        for (int k = 3; k < N; k++) t_mgmt(mac_of(k), 1, 0);
        t_learn(mac_of(16), 4, "R7");
        t_lookup(mac_of(2), "R7");
        t_lookup(mac_of(0), "R7");
        t_mgmt(mac_of(16), 1, 0);
        t_learn(mac_of(17), 5, "R7");
        t_lookup(mac_of(1), "R7");
        t_lookup(mac_of(0), "R7");
        t_mgmt(mac_of(17), 1, 0);
        t_mgmt(mac_of(0), 1, 1);
        t_learn(mac_of(18), 6, "R9");
        t_lookup(mac_of(18), "R9");
        for (int k = 3; k < N; k++) t_lookup(mac_of(k), "R6");
        t_mgmt(mac_of(5), 0, 0);
        t_learn(mac_of(18), 6, "R10");
        t_lookup(mac_of(5), "R10");
        t_mgmt(mac_of(5), 1, 0);
        t_learn(mac_of(19), 7, "R10");
        t_lookup(mac_of(18), "R10");
        t_lookup(mac_of(19), "R10");

        // R5 aging, R6 pinned survives
        do_reset();
        age_limit = 4'd3;
        t_learn(mac_of(0), 1, "R5");
        t_learn(mac_of(1), 2, "R5");
        t_mgmt(mac_of(1), 1, 0);
        t_tick(); t_tick();
        t_lookup(mac_of(0), "R5");
        t_tick(); t_tick();
        t_lookup(mac_of(0), "R5");
        t_tick(); t_tick(); t_tick();
        t_lookup(mac_of(0), "R5");
        t_lookup(mac_of(1), "R6");
        age_limit = 4'd0;
        t_learn(mac_of(2), 3, "R5");
        for (int i = 0; i < 20; i++) t_tick();
        t_lookup(mac_of(2), "R5");

        // Random mix against the model
        do_reset();
        age_limit = 4'd9;
        for (int n = 0; n < 4000; n++) begin
            int r, k;
            r = int'($urandom % 100);
            k = int'($urandom % 28);
            if (r < 45)      t_lookup(mac_of(k), "R2");
            else if (r < 78) t_learn(mac_of(k), int'($urandom % 16), "R9");
            else if (r < 86) t_mgmt(mac_of(k), ($urandom % 4) == 0, ($urandom % 3) == 0);
            else             t_tick();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule